// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This block holds the status-reporting registers of a measuring instrument's remote-control interface. Single-cycle event strobes land in a sticky 8-bit event register. An event enable register masks that register, and the masked result becomes one summary bit of an 8-bit status byte. The status byte also carries an output-queue-not-empty flag and a summary flag that comes from a secondary event register outside this block. A service request enable register masks the status byte, and the masked bits form a master summary bit. That master summary bit drives the service request line.

The command parser upstream drives a small command port. It issues one operation per cycle. The operations are: read the status byte, read the event register and clear it, write or read either enable register, clear status, notify an interface switch, and power-on. Read results come back on a registered response port. The live status byte, the live event register and the service request line are also available as outputs at all times.

Top module: `status_report_unit`

## Requirements
- R1: A high on `ev_strobe[i]` for one cycle sets event bit i on the next clock edge, and the bit stays set until a clear condition occurs. The bit meanings are: 7 power-on, 6 user request, 5 command error, 4 execution error, 3 device-dependent error, 2 query error, 1 request control, 0 operation complete.
- R2: When an event strobe and any event clear fall in the same cycle, the strobed bit ends that cycle set.
- R3: Status byte bit 5 is 1 exactly when the event register AND the event enable register is nonzero.
- R4: Status byte bit 4 follows `queue_nonempty`. Bit 0 follows `sec_summary`. Bits 7, 3, 2 and 1 always read 0.
- R5: Status byte bit 6 is the OR of status bits 7..0, excluding bit 6, each ANDed with the matching service request enable bit. `srq` equals status byte bit 6.
- R6: Command 2 (read event status) returns the event register value held before the edge, then clears the event register.
- R7: Command 7 (clear status) clears the event register and leaves both enable registers unchanged.
- R8: Command 8 (interface switch) clears the event register.
- R9: Command 9 (power-on), and `rst_n` low at a clock edge, clear the event register and both enable registers.
- R10: Command 1 (read status byte) returns the current status byte. It changes neither the event register nor bit 6.
- R11: Commands 3 and 5 write `cmd_wdata` into the event enable and service request enable registers. Commands 4 and 6 read them back. Service request enable bit 6 always reads 0.
- R12: The command codes are 0 idle, 1 to 9 as above. Each read command with `cmd_valid` high raises `rsp_valid`, with its data on `rsp_data`, for the one cycle after the command's clock edge. Code 0 and the write and clear commands raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as power-on |
| ev_strobe | input | 8 | Per-bit event pulses |
| sec_summary | input | 1 | Summary flag of the secondary event register |
| queue_nonempty | input | 1 | Output queue holds a message |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_wdata | input | 8 | Write data for enable registers |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Read response data |
| stb_out | output | 8 | Live status byte |
| esr_out | output | 8 | Live event register |
| srq | output | 1 | Service request line |

## Verification
Two things can land in one cycle: an event strobe and a clear of the event register, where the clear is the read-and-clear query, clear status, interface switch or power-on. The bench drives a strobe on a fresh bit in the same cycle as each kind of clear. For the query, it judges that the response carries the value from before the edge while the strobed bit survives the edge. It also drives a status-byte read while the master summary is set, and checks that the response shows bit 6 and that both `srq` and the event register are unchanged afterwards.

// File: rtl/sru_pkg.sv
// Shared definitions for the status reporting unit.
// Assumes an 8-bit event register and an 8-bit status byte.
package sru_pkg;
    localparam int EV_W   = 8;
    localparam int SB_W   = 8;
    localparam int OP_W   = 4;

    // Status byte bit positions (decoded by the external reader)
    localparam int SB_SEC_POS = 0;
    localparam int SB_MAV_POS = 4;
    localparam int SB_ESB_POS = 5;
    localparam int SB_MSS_POS = 6;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 4'd0,
        OP_RD_STB  = 4'd1,
        OP_RD_ESR  = 4'd2,
        OP_WR_ESE  = 4'd3,
        OP_RD_ESE  = 4'd4,
        OP_WR_SRE  = 4'd5,
        OP_RD_SRE  = 4'd6,
        OP_CLS     = 4'd7,
        OP_IFSW    = 4'd8,
        OP_PWRON   = 4'd9
    } sru_op_e;
endpackage

// File: rtl/sru_event_reg.sv
// Sticky event register with its enable mask and the masked summary.
// Assumes strobes are synchronous single-cycle pulses; a strobe beats a
// clear in the same cycle so no event is lost.
module sru_event_reg
    import sru_pkg::*;
#(
    parameter int W = EV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strobe,
    input  logic         ev_clr,
    input  logic         ese_we,
    input  logic [W-1:0] ese_wdata,
    input  logic         ese_clr,
    output logic [W-1:0] esr,
    output logic [W-1:0] ese,
    output logic         summary
);
    logic [W-1:0] esr_q;

    // One sticky cell per event bit
    for (genvar g = 0; g < W; g++) begin : g_cell
        // Set on strobe, else clear on any clear condition, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                esr_q[g] <= 1'b0;
            else if (strobe[g])
                esr_q[g] <= 1'b1;
            else if (ev_clr)
                esr_q[g] <= 1'b0;
        end
    end

    // Event enable register: written by command, zeroed at power-on
    always_ff @(posedge clk) begin
        if (!rst_n || ese_clr)
            ese <= '0;
        else if (ese_we)
            ese <= ese_wdata;
    end

    // Masked summary of latched events
    always_comb summary = |(esr_q & ese);

    assign esr = esr_q;

    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_clr |=> ((esr_q & $past(esr_q)) == $past(esr_q)));
    a_r1_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe) |=> ((esr_q & $past(strobe)) == $past(strobe)));
    a_r2_clear_keeps_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clr |=> (esr_q == $past(strobe)));
endmodule

// File: rtl/sru_status_byte.sv
// Status byte assembly, service request enable register and master summary.
// Assumes inputs are synchronous; the status byte is combinational so it
// follows its sources within the cycle.
module sru_status_byte
    import sru_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         esb,
    input  logic         mav,
    input  logic         sec,
    input  logic         sre_we,
    input  logic [W-1:0] sre_wdata,
    input  logic         sre_clr,
    output logic [W-1:0] stb,
    output logic [W-1:0] sre,
    output logic         mss
);
    localparam logic [W-1:0] MSS_MASK = W'(1) << SB_MSS_POS;

    logic [W-1:0] raw;

    // Service request enable register; the master summary bit is not maskable
    always_ff @(posedge clk) begin
        if (!rst_n || sre_clr)
            sre <= '0;
        else if (sre_we)
            sre <= sre_wdata & ~MSS_MASK;
    end

    // Place each source at its bit; unlisted bits stay zero
    always_comb begin
        raw = '0;
        raw[SB_SEC_POS] = sec;
        raw[SB_MAV_POS] = mav;
        raw[SB_ESB_POS] = esb;
    end

    // Master summary over enabled bits, then merged into the byte
    always_comb begin
        mss = |(raw & sre);
        stb = raw | (mss ? MSS_MASK : '0);
    end

    a_r11_sre_mss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sre_we |=> !sre[SB_MSS_POS]);
    a_r9_sre_poweron: assert property (@(posedge clk) disable iff (!rst_n)
        sre_clr |=> (sre == '0));
endmodule

// File: rtl/sru_cmd_dec.sv
// Command decode and registered read-response path.
// Assumes at most one command per cycle; reads sample the state before the edge.
module sru_cmd_dec
    import sru_pkg::*;
#(
    parameter int W = EV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [W-1:0]    stb,
    input  logic [W-1:0]    esr,
    input  logic [W-1:0]    ese,
    input  logic [W-1:0]    sre,
    output logic            ev_clr,
    output logic            ese_we,
    output logic            sre_we,
    output logic            en_clr,
    output logic            rsp_valid,
    output logic [W-1:0]    rsp_data
);
    sru_op_e op;
    logic    rd_hit;
    logic [W-1:0] rd_mux;

    // Decode strobes for the register blocks
    always_comb begin
        op     = sru_op_e'(cmd_op);
        ev_clr = 1'b0;
        ese_we = 1'b0;
        sre_we = 1'b0;
        en_clr = 1'b0;
        rd_hit = 1'b0;
        rd_mux = '0;
        if (cmd_valid) begin
            case (op)
                OP_RD_STB: begin rd_hit = 1'b1; rd_mux = stb; end
                OP_RD_ESR: begin rd_hit = 1'b1; rd_mux = esr; ev_clr = 1'b1; end
                OP_WR_ESE: ese_we = 1'b1;
                OP_RD_ESE: begin rd_hit = 1'b1; rd_mux = ese; end
                OP_WR_SRE: sre_we = 1'b1;
                OP_RD_SRE: begin rd_hit = 1'b1; rd_mux = sre; end
                OP_CLS:    ev_clr = 1'b1;
                OP_IFSW:   ev_clr = 1'b1;
                OP_PWRON:  begin ev_clr = 1'b1; en_clr = 1'b1; end
                default:   ;
            endcase
        end
    end

    // Register the response one cycle after the command edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_hit;
            rsp_data  <= rd_hit ? rd_mux : '0;
        end
    end

    a_r12_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ese_we, sre_we, rd_hit, en_clr && !ev_clr}) <= 1);
    a_r12_rsp_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
endmodule

// File: rtl/status_report_unit.sv
// Top of the status reporting unit: event register, status byte, command port.
// Assumes an upstream parser issues commands; no bus physical layer here.
module status_report_unit
    import sru_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_strobe,
    input  logic            sec_summary,
    input  logic            queue_nonempty,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [EV_W-1:0] cmd_wdata,
    output logic            rsp_valid,
    output logic [SB_W-1:0] rsp_data,
    output logic [SB_W-1:0] stb_out,
    output logic [EV_W-1:0] esr_out,
    output logic            srq
);
    logic            ev_clr, ese_we, sre_we, en_clr, esb, mss;
    logic [EV_W-1:0] esr, ese;
    logic [SB_W-1:0] stb, sre;

    sru_event_reg #(.W(EV_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .strobe(ev_strobe), .ev_clr(ev_clr),
        .ese_we(ese_we), .ese_wdata(cmd_wdata), .ese_clr(en_clr),
        .esr(esr), .ese(ese), .summary(esb)
    );

    sru_status_byte #(.W(SB_W)) u_sb (
        .clk(clk), .rst_n(rst_n), .esb(esb), .mav(queue_nonempty),
        .sec(sec_summary), .sre_we(sre_we), .sre_wdata(cmd_wdata),
        .sre_clr(en_clr), .stb(stb), .sre(sre), .mss(mss)
    );

    sru_cmd_dec #(.W(EV_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .stb(stb), .esr(esr), .ese(ese), .sre(sre),
        .ev_clr(ev_clr), .ese_we(ese_we), .sre_we(sre_we), .en_clr(en_clr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Drive outputs from the sub-blocks
    always_comb begin
        stb_out = stb;
        esr_out = esr;
        srq     = mss;
    end

    a_r5_srq_needs_enabled_bit: assert property (@(posedge clk) disable iff (!rst_n)
        srq |-> ((stb_out & sre & ~(SB_W'(1) << SB_MSS_POS)) != '0));
    a_r10_stb_read_keeps_esr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD_STB && ev_strobe == '0) |=> $stable(esr_out));
    a_r7_cls_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLS) |=> ($stable(ese) && $stable(sre)));
    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_out & 8'h8E) == 8'h00);
endmodule

// File: tb/status_report_unit_test.sv
`timescale 1ns/1ps
module status_report_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_strobe = '0;
    logic       sec_summary = 1'b0;
    logic       queue_nonempty = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data, stb_out, esr_out;
    logic       srq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_esr = '0, m_ese = '0, m_sre = '0;

    typedef struct { logic [7:0] data; string tag; } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    status_report_unit uut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .sec_summary(sec_summary),
        .queue_nonempty(queue_nonempty), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .stb_out(stb_out), .esr_out(esr_out), .srq(srq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_stb(input logic q, input logic s);
        logic [7:0] b;
        b = 8'h00;
        b[0] = s;
        b[4] = q;
        b[5] = |(m_esr & m_ese);
        b[6] = |(b & m_sre & 8'hBF);
        return b;
    endfunction

    // Drive one cycle at a falling edge, update the model, check after the edge
    task automatic drive(input string tag, input logic v, input logic [3:0] op,
                         input logic [7:0] wd, input logic [7:0] strb,
                         input logic q, input logic s);
        logic clr;
        exp_t e;
        cmd_valid = v; cmd_op = op; cmd_wdata = wd; ev_strobe = strb;
        queue_nonempty = q; sec_summary = s;
        clr = 1'b0;
        if (v) begin
            e.tag = tag;
            case (op)
                4'd1: begin e.data = model_stb(q, s); expq.push_back(e); end
                4'd2: begin e.data = m_esr; expq.push_back(e); clr = 1'b1; end
                4'd3: m_ese = wd;
                4'd4: begin e.data = m_ese; expq.push_back(e); end
                4'd5: m_sre = wd & 8'hBF;
                4'd6: begin e.data = m_sre; expq.push_back(e); end
                4'd7, 4'd8: clr = 1'b1;
                4'd9: begin clr = 1'b1; m_ese = '0; m_sre = '0; end
                default: ;
            endcase
        end
        m_esr = (clr ? 8'h00 : m_esr) | strb;
        @(negedge clk);
        check({tag, " esr"}, esr_out, m_esr);
        check({tag, " stb"}, stb_out, model_stb(q, s));
        check({tag, " srq"}, {7'd0, srq}, {7'd0, model_stb(q, s)[6]});
        cmd_valid = 1'b0; ev_strobe = '0;
    endtask

    // Monitor: pop expected responses as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (expq.size() == 0) begin
                    check("R12 unexpected rsp", rsp_data, 8'hxx);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({e.tag, " rsp"}, rsp_data, e.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check("R9 reset stb", stb_out, 8'h00);
        check("R9 reset esr", esr_out, 8'h00);
        // R1 strobes on operation complete then power-on bit, sticky
        drive("R1 opc", 0, 4'd0, 8'h00, 8'h01, 0, 0);
        drive("R1 pon", 0, 4'd0, 8'h00, 8'h80, 0, 0);
        drive("R1 hold", 0, 4'd0, 8'h00, 8'h00, 0, 0);
        check("R1 sticky", esr_out, 8'h81);
        // R3 summary off while masked, then on
        check("R3 masked", stb_out, 8'h00);
        drive("R11 wr ese", 1, 4'd3, 8'h01, 8'h00, 0, 0);
        check("R3 esb set", stb_out, 8'h20);
        drive("R11 rd ese", 1, 4'd4, 8'h00, 8'h00, 0, 0);
        // R4 queue and secondary flags
        drive("R4 flags", 0, 4'd0, 8'h00, 8'h00, 1, 1);
        check("R4 bits", stb_out, 8'h31);
        // R5 master summary through service request enable
        drive("R5 wr sre", 1, 4'd5, 8'h20, 8'h00, 0, 0);
        check("R5 srq", {7'd0, srq}, 8'h01);
        drive("R5 mav only", 1, 4'd5, 8'h10, 8'h00, 0, 0);
        check("R5 masked out", stb_out, 8'h20);
        drive("R5 mav on", 0, 4'd0, 8'h00, 8'h00, 1, 0);
        check("R5 mav srq", stb_out, 8'h70);
        drive("R11 wr sre ff", 1, 4'd5, 8'hFF, 8'h00, 0, 0);
        drive("R11 rd sre", 1, 4'd6, 8'h00, 8'h00, 0, 0);
        // R10 read status byte leaves summary
        drive("R10 rd stb", 1, 4'd1, 8'h00, 8'h00, 0, 0);
        drive("R10 after", 0, 4'd0, 8'h00, 8'h00, 0, 0);
        check("R10 srq kept", {7'd0, srq}, 8'h01);
        // R6 read-and-clear with a same-cycle strobe (R2)
        drive("R6 rd esr", 1, 4'd2, 8'h00, 8'h04, 0, 0);
        check("R2 strobe survives", esr_out, 8'h04);
        drive("R6 rd again", 1, 4'd2, 8'h00, 8'h00, 0, 0);
        check("R6 cleared", esr_out, 8'h00);
        // R7 clear status vs strobe, enables kept
        drive("R7 ev", 0, 4'd0, 8'h00, 8'h21, 0, 0);
        drive("R2 cls+strobe", 1, 4'd7, 8'h00, 8'h08, 0, 0);
        drive("R7 cls", 1, 4'd7, 8'h00, 8'h00, 0, 0);
        drive("R7 ese kept", 1, 4'd4, 8'h00, 8'h00, 0, 0);
        drive("R7 sre kept", 1, 4'd6, 8'h00, 8'h00, 0, 0);
        // R8 interface switch
        drive("R8 ev", 0, 4'd0, 8'h00, 8'h41, 0, 0);
        drive("R8 ifsw+strobe", 1, 4'd8, 8'h00, 8'h02, 0, 0);
        drive("R8 ifsw", 1, 4'd8, 8'h00, 8'h00, 0, 0);
        // R9 power-on command
        drive("R9 ev", 0, 4'd0, 8'h00, 8'h11, 0, 0);
        drive("R9 pwron", 1, 4'd9, 8'h00, 8'h00, 1, 1);
        drive("R9 ese zero", 1, 4'd4, 8'h00, 8'h00, 0, 0);
        drive("R9 sre zero", 1, 4'd6, 8'h00, 8'h00, 0, 0);
        // R12 idle code gives no response
        drive("R12 idle", 1, 4'd0, 8'h00, 8'h00, 0, 0);
        check("R12 no rsp", {7'd0, rsp_valid}, 8'h00);
        // R9 reset pin mid-run
        drive("R9 prep", 1, 4'd3, 8'hFF, 8'hFF, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_esr = '0; m_ese = '0; m_sre = '0;
        drive("R9 after rst", 1, 4'd4, 8'h00, 8'h00, 0, 0);
        @(negedge clk);
        check("R12 queue drained", 8'(expq.size()), 8'h00);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule